// File: doc/BRIEF.md
# Flash Block Lock-Bit Controller

This block models the command layer that guards the erase blocks of a small parallel NOR flash. A host issues bus write cycles (an address and a data word). The block decodes command codes from the low byte of the data, and it holds one lock bit per erase block. Program and erase requests that target a locked block are refused. The storage array is a small register file that resets to all ones. The time a lock, program or erase operation keeps the controller busy is a fixed cycle count set by a parameter.

Reads are combinational from `rd_addr`, and their meaning depends on the current read mode. In array mode a read returns the stored word. In status mode it returns the status byte. In information mode a read returns the lock state of the block that the address selects. A test input can force the next lock operation to fail, so that the error flags can be exercised.

Top module: `flk_lock_ctrl`

## Requirements
- R1: After reset `ready` is 1, the read mode is array, every lock bit is 0, every array word reads FFFFh, and a status read returns 0080h.
- R2: The write pair 60h then 01h (the second address selecting the block, address = {block, offset}) locks that block. `ready` reads 0 from the cycle after the confirm write for exactly BUSY_CYC cycles.
- R3: The write pair 60h then D0h unlocks the addressed block after the same busy time.
- R4: After command 90h, a read at block base + 2 returns that block's lock bit in bit 0 with bits 15..1 zero, and a read at any other offset returns 0000h.
- R5: While `fail_inject` has been seen since the last lock operation, the next lock operation leaves the lock bit unchanged. It sets status bit 4 for a set and status bit 5 for a clear.
- R6: A confirm byte other than 01h or D0h after 60h sets status bits 4 and 5, starts no operation, and leaves `ready` at 1.
- R7: Status bits 5, 4 and 1 stay set until the clear-status command 50h is written.
- R8: After any two-cycle command is confirmed, reads return status (bit 7 = ready) until FFh is written. Command 70h also selects status reads.
- R9: Writes that arrive while `ready` is 0 are ignored.
- R10: The write pair 40h then a data word programs that word at the second address if its block is unlocked. If the block is locked, status bit 1 is set and the word is left unchanged.
- R11: The write pair 20h then D0h sets every word of an unlocked block to FFFFh. If the block is locked, status bit 1 is set and no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address {block, offset} |
| wr_data | input | DW | Write data, command code in bits 7..0 |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DW | Read data, meaning set by read mode |
| ready | output | 1 | 1 when idle, 0 while an operation runs |
| fail_inject | input | 1 | Forces the next lock operation to fail |

## Verification
The hardest situations to reach are a failing set or clear, which a healthy model never produces, and a command that arrives in the middle of a busy window. The stimulus pulses `fail_inject` before a lock sequence to reach both error flags. It places a 90h write two cycles after a confirm, so that the ignored command would visibly switch the read mode if it were accepted. The exact end of the busy window is sampled on both sides of the final cycle.

// File: rtl/flk_pkg.sv
package flk_pkg;
    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_INFO} rmode_e;
    typedef enum logic [1:0] {PD_NONE, PD_LOCK, PD_PROG, PD_ERASE} pend_e;
    typedef enum logic [2:0] {OP_IDLE, OP_SET, OP_CLR, OP_PROG, OP_ERASE} op_e;
    typedef enum logic [2:0] {
        C_RD_ARRAY, C_RD_STATUS, C_RD_INFO, C_CLR_STAT,
        C_LOCK_SU, C_PROG_SU, C_ERASE_SU, C_NONE
    } cmd_e;

    localparam logic [7:0] K_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] K_RD_STATUS = 8'h70;
    localparam logic [7:0] K_RD_INFO   = 8'h90;
    localparam logic [7:0] K_CLR_STAT  = 8'h50;
    localparam logic [7:0] K_LOCK_SU   = 8'h60;
    localparam logic [7:0] K_PROG_SU   = 8'h40;
    localparam logic [7:0] K_ERASE_SU  = 8'h20;
    localparam logic [7:0] K_CONF_SET  = 8'h01;
    localparam logic [7:0] K_CONF_GO   = 8'hD0;
    localparam int         INFO_OFS    = 2;
endpackage

// File: rtl/flk_cmd_decode.sv
module flk_cmd_decode
    import flk_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cmd
);
    always_comb begin
        unique case (code)
            K_RD_ARRAY:  cmd = C_RD_ARRAY;
            K_RD_STATUS: cmd = C_RD_STATUS;
            K_RD_INFO:   cmd = C_RD_INFO;
            K_CLR_STAT:  cmd = C_CLR_STAT;
            K_LOCK_SU:   cmd = C_LOCK_SU;
            K_PROG_SU:   cmd = C_PROG_SU;
            K_ERASE_SU:  cmd = C_ERASE_SU;
            default:     cmd = C_NONE;
        endcase
    end
endmodule

// File: rtl/flk_busy_timer.sv
module flk_busy_timer #(
    parameter int CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (start)     cnt_d = CW'(CYC);
        else if (busy) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flk_store.sv
module flk_store #(
    parameter int NBLK      = 4,
    parameter int BLK_WORDS = 8,
    parameter int DW        = 16,
    localparam int BLK_W    = $clog2(NBLK),
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int ADDR_W   = BLK_W + OFF_W,
    localparam int NWORDS   = NBLK * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_set,
    input  logic              lk_clr,
    input  logic [BLK_W-1:0]  op_blk,
    input  logic              pg_en,
    input  logic [OFF_W-1:0]  pg_off,
    input  logic [DW-1:0]     pg_data,
    input  logic              er_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_word,
    output logic [NBLK-1:0]   lock_bits
);
    logic [DW-1:0]   arr_d [NWORDS];
    logic [DW-1:0]   arr_q [NWORDS];
    logic [NBLK-1:0] lock_d, lock_q;

    assign rd_word   = arr_q[rd_addr];
    assign lock_bits = lock_q;

    always_comb begin
        lock_d = lock_q;
        if (lk_set) lock_d[op_blk] = 1'b1;
        if (lk_clr) lock_d[op_blk] = 1'b0;
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        for (genvar w = 0; w < BLK_WORDS; w++) begin : g_word
            localparam int IDX = b * BLK_WORDS + w;
            always_comb begin
                arr_d[IDX] = arr_q[IDX];
                if (er_en && op_blk == BLK_W'(b))
                    arr_d[IDX] = '1;
                if (pg_en && op_blk == BLK_W'(b) && pg_off == OFF_W'(w))
                    arr_d[IDX] = arr_q[IDX] & pg_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) arr_q[IDX] <= '1;
                else        arr_q[IDX] <= arr_d[IDX];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end
endmodule

// File: rtl/flk_lock_ctrl.sv
module flk_lock_ctrl
    import flk_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int BLK_WORDS = 8,
    parameter int DW        = 16,
    parameter int BUSY_CYC  = 6,
    localparam int BLK_W    = $clog2(NBLK),
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int ADDR_W   = BLK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              ready,
    input  logic              fail_inject
);
    typedef struct packed {
        rmode_e           mode;
        pend_e            pend;
        op_e              op;
        logic [BLK_W-1:0] blk;
        logic [OFF_W-1:0] off;
        logic [DW-1:0]    data;
        logic             err_set;
        logic             err_clr;
        logic             err_lock;
        logic             fail_arm;
    } ctl_t;

    ctl_t st_d, st_q;

    cmd_e             cmd;
    logic             t_start, t_busy, t_done;
    logic             lk_set, lk_clr, pg_en, er_en;
    logic [DW-1:0]    arr_word;
    logic [NBLK-1:0]  lock_bits;
    logic [BLK_W-1:0] wr_blk, rd_blk, op_blk;
    logic [OFF_W-1:0] rd_off;
    logic [7:0]       code;
    logic [7:0]       status;

    assign code   = wr_data[7:0];
    assign wr_blk = wr_addr[ADDR_W-1:OFF_W];
    assign rd_blk = rd_addr[ADDR_W-1:OFF_W];
    assign rd_off = rd_addr[OFF_W-1:0];
    assign op_blk = st_q.blk;
    assign ready  = !t_busy;

    flk_cmd_decode u_dec (
        .code (code),
        .cmd  (cmd)
    );

    flk_busy_timer #(.CYC(BUSY_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .busy  (t_busy),
        .done  (t_done)
    );

    flk_store #(.NBLK(NBLK), .BLK_WORDS(BLK_WORDS), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (lk_set),
        .lk_clr    (lk_clr),
        .op_blk    (op_blk),
        .pg_en     (pg_en),
        .pg_off    (st_q.off),
        .pg_data   (st_q.data),
        .er_en     (er_en),
        .rd_addr   (rd_addr),
        .rd_word   (arr_word),
        .lock_bits (lock_bits)
    );

    // Next-state computation
    always_comb begin
        st_d    = st_q;
        lk_set  = 1'b0;
        lk_clr  = 1'b0;
        pg_en   = 1'b0;
        er_en   = 1'b0;
        t_start = 1'b0;

        // Completion of a running operation
        if (t_done) begin
            unique case (st_q.op)
                OP_SET: begin
                    if (st_q.fail_arm) begin
                        st_d.err_set  = 1'b1;
                        st_d.fail_arm = 1'b0;
                    end else begin
                        lk_set = 1'b1;
                    end
                end
                OP_CLR: begin
                    if (st_q.fail_arm) begin
                        st_d.err_clr  = 1'b1;
                        st_d.fail_arm = 1'b0;
                    end else begin
                        lk_clr = 1'b1;
                    end
                end
                OP_PROG:  pg_en = 1'b1;
                OP_ERASE: er_en = 1'b1;
                default: ;
            endcase
            st_d.op = OP_IDLE;
        end

        if (fail_inject) st_d.fail_arm = 1'b1;

        // Bus writes, accepted only while idle
        if (wr_en && !t_busy) begin
            if (st_q.pend != PD_NONE) begin
                st_d.pend = PD_NONE;
                st_d.mode = RM_STATUS;
                st_d.blk  = wr_blk;
                st_d.off  = wr_addr[OFF_W-1:0];
                st_d.data = wr_data;
                unique case (st_q.pend)
                    PD_LOCK: begin
                        if (code == K_CONF_SET) begin
                            st_d.op = OP_SET;
                            t_start = 1'b1;
                        end else if (code == K_CONF_GO) begin
                            st_d.op = OP_CLR;
                            t_start = 1'b1;
                        end else begin
                            st_d.err_set = 1'b1;
                            st_d.err_clr = 1'b1;
                        end
                    end
                    PD_PROG: begin
                        if (lock_bits[wr_blk]) begin
                            st_d.err_lock = 1'b1;
                        end else begin
                            st_d.op = OP_PROG;
                            t_start = 1'b1;
                        end
                    end
                    PD_ERASE: begin
                        if (code != K_CONF_GO) begin
                            st_d.err_set = 1'b1;
                            st_d.err_clr = 1'b1;
                        end else if (lock_bits[wr_blk]) begin
                            st_d.err_lock = 1'b1;
                        end else begin
                            st_d.op = OP_ERASE;
                            t_start = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else begin
                unique case (cmd)
                    C_RD_ARRAY:  st_d.mode = RM_ARRAY;
                    C_RD_STATUS: st_d.mode = RM_STATUS;
                    C_RD_INFO:   st_d.mode = RM_INFO;
                    C_CLR_STAT: begin
                        st_d.err_set  = 1'b0;
                        st_d.err_clr  = 1'b0;
                        st_d.err_lock = 1'b0;
                    end
                    C_LOCK_SU:   st_d.pend = PD_LOCK;
                    C_PROG_SU:   st_d.pend = PD_PROG;
                    C_ERASE_SU:  st_d.pend = PD_ERASE;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: RM_ARRAY, pend: PD_NONE, op: OP_IDLE,
                      blk: '0, off: '0, data: '0,
                      err_set: 1'b0, err_clr: 1'b0, err_lock: 1'b0,
                      fail_arm: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Read path
    assign status = {ready, 1'b0, st_q.err_clr, st_q.err_set,
                     2'b00, st_q.err_lock, 1'b0};

    always_comb begin
        unique case (st_q.mode)
            RM_STATUS: rd_data = {{(DW-8){1'b0}}, status};
            RM_INFO: begin
                rd_data = '0;
                if (rd_off == OFF_W'(INFO_OFS)) rd_data[0] = lock_bits[rd_blk];
            end
            default:   rd_data = arr_word;
        endcase
    end
endmodule

// File: rtl/flk_lock_ctrl_chk.sv
module flk_lock_ctrl_chk
    import flk_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int DW    = 16,
    parameter int BLK_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [DW-1:0]    wr_data,
    input logic             ready,
    input logic [DW-1:0]    rd_data,
    input rmode_e           mode,
    input pend_e            pend,
    input logic             err_set,
    input logic             err_lock,
    input logic [NBLK-1:0]  lock_bits,
    input logic             t_done,
    input logic             t_start,
    input logic             pg_en,
    input logic             er_en,
    input logic [BLK_W-1:0] op_blk
);
    logic clr_cmd;
    assign clr_cmd = wr_en && ready && pend == PD_NONE && wr_data[7:0] == K_CLR_STAT;

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        t_start |=> !ready);                                       // R2

    AST_LOCK_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_bits) |-> $past(t_done));                    // R9

    AST_INFO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mode == RM_INFO |-> rd_data[DW-1:1] == '0);                // R4

    AST_STATUS_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        mode == RM_STATUS |-> rd_data[7] == ready);                // R8

    AST_SET_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_set && !clr_cmd |=> err_set);                          // R7

    AST_LOCK_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_lock && !clr_cmd |=> err_lock);                        // R7

    AST_NO_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_en || er_en) |-> !lock_bits[op_blk]);                  // R10
endmodule

bind flk_lock_ctrl flk_lock_ctrl_chk #(.NBLK(NBLK), .DW(DW), .BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ready     (ready),
    .rd_data   (rd_data),
    .mode      (st_q.mode),
    .pend      (st_q.pend),
    .err_set   (st_q.err_set),
    .err_lock  (st_q.err_lock),
    .lock_bits (lock_bits),
    .t_done    (t_done),
    .t_start   (t_start),
    .pg_en     (pg_en),
    .er_en     (er_en),
    .op_blk    (op_blk)
);

// File: tb/flk_lock_ctrl_bench.sv
module flk_lock_ctrl_bench;
    localparam int NBLK = 4, BW = 8, DW = 16, BC = 6, AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          ready;
    logic          fail_inject = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        bit            is_ready;
        logic [DW-1:0] exp;
        string         tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    flk_lock_ctrl #(.NBLK(NBLK), .BLK_WORDS(BW), .DW(DW), .BUSY_CYC(BC)) u_flk_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ready(ready), .fail_inject(fail_inject)
    );

    // Monitor: pops expected items and compares
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [DW-1:0] act;
                it = sb.pop_front();
                act = it.is_ready ? {{(DW-1){1'b0}}, ready} : rd_data;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic exp_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        it.is_ready = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_rdy(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_ready = 1'b1; it.exp = {{(DW-1){1'b0}}, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic lock_op(input logic [AW-1:0] a, input logic [7:0] conf);
        wr(a, 16'h0060);
        wr(a, {8'h00, conf});
        repeat (BC + 2) @(posedge clk);
    endtask

    task automatic pulse_fail();
        @(negedge clk);
        fail_inject = 1'b1;
        @(negedge clk);
        fail_inject = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_rdy(1'b1, "R1 ready after reset");
        exp_rd(5'd0, 16'hFFFF, "R1 array erased");
        wr(5'd0, 16'h0090);
        exp_rd(5'd2, 16'h0000, "R1 block0 unlocked");
        wr(5'd0, 16'h0070);
        exp_rd(5'd0, 16'h0080, "R1 status 80h");

        // R2 set lock block 1, busy length, R9 write during busy
        wr(5'd8, 16'h0060);
        wr(5'd8, 16'h0001);
        wr(5'd0, 16'h0090);
        repeat (3) @(posedge clk);
        exp_rdy(1'b0, "R2 busy in final cycle");
        exp_rdy(1'b1, "R2 ready after BUSY_CYC");
        exp_rd(5'd0, 16'h0080, "R9 ignored 90h, R8 status mode");
        wr(5'd0, 16'h00FF);
        wr(5'd0, 16'h0090);
        exp_rd(5'd10, 16'h0001, "R2 R4 block1 locked");
        exp_rd(5'd11, 16'h0000, "R4 other offset zero");
        exp_rd(5'd2, 16'h0000, "R4 block0 unlocked");

        // R10 program locked block rejected
        wr(5'd0, 16'h00FF);
        wr(5'd9, 16'h0040);
        wr(5'd9, 16'h1234);
        exp_rd(5'd0, 16'h0082, "R10 locked program error bit1");
        exp_rdy(1'b1, "R10 no operation started");
        wr(5'd0, 16'h00FF);
        exp_rd(5'd9, 16'hFFFF, "R10 locked word unchanged");
        wr(5'd0, 16'h0050);
        wr(5'd0, 16'h0070);
        exp_rd(5'd0, 16'h0080, "R7 clear status");

        // R10 program unlocked block
        wr(5'd3, 16'h0040);
        wr(5'd3, 16'hA5C3);
        repeat (BC + 2) @(posedge clk);
        wr(5'd0, 16'h00FF);
        exp_rd(5'd3, 16'hA5C3, "R10 word programmed");

        // R6 bad confirm
        wr(5'd16, 16'h0060);
        wr(5'd16, 16'h0033);
        exp_rdy(1'b1, "R6 no busy");
        exp_rd(5'd0, 16'h00B0, "R6 bits 5 and 4 set");
        wr(5'd0, 16'h00FF);
        exp_rd(5'd16, 16'hFFFF, "R8 array mode after FFh");
        wr(5'd0, 16'h0090);
        exp_rd(5'd18, 16'h0000, "R6 block2 not locked");

        // R7 sticky
        wr(5'd0, 16'h0070);
        exp_rd(5'd0, 16'h00B0, "R7 errors persist");
        wr(5'd0, 16'h0050);
        exp_rd(5'd0, 16'h0080, "R7 cleared by 50h");

        // R5 injected set failure
        pulse_fail();
        lock_op(5'd16, 8'h01);
        exp_rd(5'd0, 16'h0090, "R5 set failure bit4");
        wr(5'd0, 16'h0090);
        exp_rd(5'd18, 16'h0000, "R5 lock unchanged after failed set");
        wr(5'd0, 16'h0050);

        // R5 injected clear failure, then R3 real clear
        pulse_fail();
        lock_op(5'd8, 8'hD0);
        exp_rd(5'd0, 16'h00A0, "R5 clear failure bit5");
        wr(5'd0, 16'h0090);
        exp_rd(5'd10, 16'h0001, "R5 lock kept after failed clear");
        wr(5'd0, 16'h0050);
        lock_op(5'd8, 8'hD0);
        exp_rd(5'd0, 16'h0080, "R3 clear ok status");
        wr(5'd0, 16'h0090);
        exp_rd(5'd10, 16'h0000, "R3 block1 unlocked");

        // R11 erase locked / unlocked
        lock_op(5'd0, 8'h01);
        wr(5'd0, 16'h0020);
        wr(5'd0, 16'h00D0);
        exp_rd(5'd0, 16'h0082, "R11 locked erase error bit1");
        wr(5'd0, 16'h00FF);
        exp_rd(5'd3, 16'hA5C3, "R11 locked block kept");
        wr(5'd0, 16'h0050);
        lock_op(5'd0, 8'hD0);
        wr(5'd0, 16'h0020);
        wr(5'd0, 16'h00D0);
        repeat (BC + 2) @(posedge clk);
        exp_rd(5'd0, 16'h0080, "R11 erase status ok");
        wr(5'd0, 16'h00FF);
        exp_rd(5'd3, 16'hFFFF, "R11 block erased");

        repeat (4) @(negedge clk);
        finished = 1;
        summary();
    end
endmodule